// File: doc/BRIEF.md
# SMBus Host Block-Transfer Front End

This block is the register-level front end of an SMBus host controller, extended with block data transfers. Software reaches it through a byte-wide register port over a 64-byte window (6-bit offset, write and read strobes). The block decodes the registers and keeps the status bits. It hands whole transactions to an abstract bus-transaction engine. The engine receives a start pulse, the target address, command, direction and byte count. It returns read data as a strobed byte stream and ends each transaction with a done pulse that carries an error flag.

Two block modes can be chosen with a bit in the auxiliary register. In buffered mode, software fills or drains a 32-byte internal queue through the block-data port while an index moves through it. In byte-by-byte mode, each byte passes through a single holding register. Software moves the transfer forward by writing the status register to clear the byte-done flag. A last-byte bit in the control register ends a read. Kill and soft reset both abandon any transfer in progress.

Register offsets: status 0x00, control 0x02, command 0x03, address 0x04, data-0 0x05, data-1 0x06, block data 0x07, auxiliary 0x0D. All other offsets read 0.

Top module: `smbus_blk_host`

## Requirements
- R1: After reset every register reads 0. The auxiliary register keeps only bits 1:0 (bit 0 PEC enable, bit 1 buffered-mode enable), and its other bits read 0.
- R2: Status bits are: bit 0 busy, bit 1 interrupt, bit 2 device error, bit 4 killed, bit 7 byte done. A status write clears each bit written as 1, except busy, which a status write cannot clear.
- R3: Control bits are: bit 1 kill, bits 4:2 protocol (5 block data, 6 I2C block read), bit 5 last byte, bit 6 start. Start always reads back 0. A start with any other protocol sets device error.
- R4: Writing control with kill set ends the pending operation, resets the index to 0, sets killed and clears busy.
- R5: Each block-data access first wraps the index to 0 if it equals 32. In buffered mode, a write stores at the index and a read returns the byte at the index, and both post-increment it. Otherwise both use the single holding register.
- R6: A buffered read (address bit 0 = 1) starts the engine, stores the returned bytes from index 0, puts the returned count in data-0 and sets interrupt with busy held. When block-data reads bring the index up to data-0, busy clears and the index returns to 0.
- R7: A buffered write (address bit 0 = 0) starts the engine only if the index equals data-0. Otherwise it sets device error, resets the index and does not start the engine. When the engine finishes, interrupt is set and busy clears.
- R8: A byte-by-byte read ends with the first byte in the holding register and busy plus byte done set. Each status write presents the next byte and sets byte done again. If last byte is set, that write presents the final byte, sets interrupt and clears busy.
- R9: A byte-by-byte write takes the first byte from the holding register at start and sets busy and byte done. Each status write advances the index and captures the holding register. When the index reaches data-0, the engine writes data-0 bytes, after which interrupt is set and busy clears.
- R10: If the protocol is I2C block read when a byte-by-byte write reaches data-0, device error is set and the engine is not started.
- R11: Soft reset clears all status bits, resets the index to 0 and leaves no operation pending.
- R12: An engine done with the error flag set sets device error and clears busy.
- R13: The engine start is a single-cycle pulse. The engine address is address bits 7:1, and its direction is address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| soft_rst | input | 1 | Soft reset of status, index and pending operation |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for side effects) |
| reg_rdata | output | 8 | Register read data, combinational |
| eng_start | output | 1 | Transaction start pulse |
| eng_read | output | 1 | Transaction direction, 1 = read |
| eng_addr | output | 7 | Target address |
| eng_cmd | output | 8 | Command byte |
| eng_count | output | 8 | Bytes to write |
| eng_widx | input | 5 | Buffer index the engine fetches |
| eng_wbyte | output | 8 | Buffer byte at eng_widx |
| eng_rvalid | input | 1 | Read byte strobe |
| eng_rbyte | input | 8 | Read byte |
| eng_done | input | 1 | Transaction complete |
| eng_err | input | 1 | Error flag with done |
| eng_rcount | input | 8 | Byte count returned with done |

## Verification
On every cycle, the assertions check these properties: busy survives a status write in buffered mode, kill and soft reset land in their defined states, a mismatched buffered write raises device error without an engine start, start never reads back set, the auxiliary register's upper bits read zero, and the engine start lasts one cycle. Only the bench's scenarios can show the data paths. These are the byte order captured by the engine, the order in which bytes are handed back in both modes, the index wrap at 32, the count landing in data-0, and the status sequence across a full byte-by-byte handshake.

// File: rtl/smbus_blk_host.sv
module smbus_blk_host #(
  parameter int BUF_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       eng_start,
  output logic       eng_read,
  output logic [6:0] eng_addr,
  output logic [7:0] eng_cmd,
  output logic [7:0] eng_count,
  input  logic [4:0] eng_widx,
  output logic [7:0] eng_wbyte,
  input  logic       eng_rvalid,
  input  logic [7:0] eng_rbyte,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic [7:0] eng_rcount
);
  localparam int IW = $clog2(BUF_DEPTH) + 1;
  localparam int AW = IW - 1;
  localparam logic [IW-1:0] DEPTH_I = IW'(BUF_DEPTH);

  localparam logic [5:0] A_STS = 6'h00, A_CTL = 6'h02, A_CMD = 6'h03, A_ADR = 6'h04,
                         A_D0 = 6'h05, A_D1 = 6'h06, A_BLK = 6'h07, A_AUX = 6'h0D;
  localparam int S_BUSY = 0, S_INTR = 1, S_DERR = 2, S_KILL = 4, S_BDONE = 7;
  localparam int C_KILL = 1, C_LAST = 5, C_START = 6;
  localparam logic [2:0] P_BLOCK = 3'd5, P_I2CRD = 3'd6;
  localparam logic [1:0] W_NONE = 2'd0, W_BUFRD = 2'd1, W_BYTRD = 2'd2, W_WR = 2'd3;

  logic [7:0] stat, ctl, r_cmd, r_adr, r_d0, r_d1, blk;
  logic [1:0] aux, wt;
  logic [IW-1:0] idx, rptr;
  logic op_done;
  logic [7:0] buffer [BUF_DEPTH];

  logic [7:0] n_stat, n_ctl, n_d0, n_blk;
  logic [1:0] n_wt;
  logic [IW-1:0] n_idx, n_rptr, widx, nidx, idx_s;
  logic n_op, bwe, start_p;
  logic [AW-1:0] bwa;
  logic [7:0] bwd;

  wire rd_dir = r_adr[0];
  wire buffered = aux[1];

  assign widx = (idx == DEPTH_I) ? '0 : idx;
  assign nidx = idx + 1'b1;
  assign idx_s = op_done ? idx : '0;

  assign eng_read  = r_adr[0];
  assign eng_addr  = r_adr[7:1];
  assign eng_cmd   = r_cmd;
  assign eng_count = r_d0;
  assign eng_wbyte = buffer[eng_widx[AW-1:0]];

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = stat;
      A_CTL:   reg_rdata = ctl;
      A_CMD:   reg_rdata = r_cmd;
      A_ADR:   reg_rdata = r_adr;
      A_D0:    reg_rdata = r_d0;
      A_D1:    reg_rdata = r_d1;
      A_BLK:   reg_rdata = buffered ? buffer[widx[AW-1:0]] : blk;
      A_AUX:   reg_rdata = {6'b0, aux};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    n_stat = stat; n_ctl = ctl; n_d0 = r_d0; n_blk = blk;
    n_wt = wt; n_idx = idx; n_rptr = rptr; n_op = op_done;
    bwe = 1'b0; bwa = '0; bwd = '0; start_p = 1'b0;

    if (eng_rvalid && wt != W_NONE) begin
      bwe = 1'b1; bwa = rptr[AW-1:0]; bwd = eng_rbyte;
      n_rptr = rptr + 1'b1;
    end

    if (eng_done && wt != W_NONE) begin
      n_wt = W_NONE;
      if (eng_err) begin
        n_stat[S_DERR] = 1'b1; n_stat[S_BUSY] = 1'b0; n_op = 1'b1;
      end else begin
        case (wt)
          W_BUFRD: begin
            n_d0 = eng_rcount; n_idx = '0; n_op = 1'b0; n_stat[S_INTR] = 1'b1;
          end
          W_BYTRD: begin
            n_d0 = eng_rcount; n_idx = '0; n_op = 1'b0; n_blk = buffer[0];
            n_stat[S_BUSY] = 1'b1; n_stat[S_BDONE] = 1'b1;
          end
          default: begin
            n_op = 1'b1; n_stat[S_INTR] = 1'b1; n_stat[S_BUSY] = 1'b0;
          end
        endcase
      end
    end

    if (reg_wr) begin
      case (reg_addr)
        A_STS: begin
          n_stat = n_stat & ~(reg_wdata & 8'hFE);
          if (!op_done && !buffered) begin
            n_idx = nidx;
            if (!rd_dir && {{(8-IW){1'b0}}, nidx} == r_d0) begin
              if (ctl[4:2] == P_I2CRD) n_stat[S_DERR] = 1'b1;
              else begin
                start_p = 1'b1; n_wt = W_WR;
              end
            end else if (!rd_dir) begin
              bwe = 1'b1; bwa = nidx[AW-1:0]; bwd = blk; n_stat[S_BDONE] = 1'b1;
            end else if (ctl[C_LAST]) begin
              n_op = 1'b1; n_blk = buffer[nidx[AW-1:0]]; n_idx = '0;
              n_stat[S_INTR] = 1'b1; n_stat[S_BUSY] = 1'b0;
            end else begin
              n_blk = buffer[nidx[AW-1:0]]; n_stat[S_BDONE] = 1'b1;
            end
          end
        end
        A_CTL: begin
          n_ctl = reg_wdata & ~(8'h1 << C_START);
          if (reg_wdata[C_START]) begin
            n_idx = idx_s; n_op = 1'b1;
            if (reg_wdata[4:2] != P_BLOCK && reg_wdata[4:2] != P_I2CRD) begin
              n_stat[S_DERR] = 1'b1;
            end else if (rd_dir) begin
              start_p = 1'b1; n_rptr = '0; n_stat[S_BUSY] = 1'b1;
              n_wt = buffered ? W_BUFRD : W_BYTRD;
            end else if (buffered) begin
              n_idx = '0;
              if ({{(8-IW){1'b0}}, idx_s} != r_d0) n_stat[S_DERR] = 1'b1;
              else begin
                start_p = 1'b1; n_wt = W_WR; n_stat[S_BUSY] = 1'b1;
              end
            end else begin
              n_op = 1'b0; n_idx = '0;
              n_stat[S_BUSY] = 1'b1; n_stat[S_BDONE] = 1'b1;
              bwe = 1'b1; bwa = '0; bwd = blk;
            end
          end
          if (reg_wdata[C_KILL]) begin
            n_op = 1'b1; n_idx = '0; n_wt = W_NONE; start_p = 1'b0;
            n_stat[S_KILL] = 1'b1; n_stat[S_BUSY] = 1'b0;
          end
        end
        A_D0: n_d0 = reg_wdata;
        A_BLK: begin
          if (buffered) begin
            bwe = 1'b1; bwa = widx[AW-1:0]; bwd = reg_wdata; n_idx = widx + 1'b1;
          end else n_blk = reg_wdata;
        end
        default: ;
      endcase
    end

    if (reg_rd && reg_addr == A_BLK && buffered) begin
      n_idx = widx + 1'b1;
      if (!op_done && {{(8-IW){1'b0}}, widx + 1'b1} == r_d0) begin
        n_op = 1'b1; n_idx = '0; n_stat[S_BUSY] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bwe) buffer[bwa] <= bwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0; ctl <= '0; r_cmd <= '0; r_adr <= '0; r_d0 <= '0; r_d1 <= '0;
      blk <= '0; aux <= '0; wt <= W_NONE; idx <= '0; rptr <= '0;
      op_done <= 1'b1; eng_start <= 1'b0;
    end else begin
      ctl <= n_ctl; r_d0 <= n_d0; blk <= n_blk; rptr <= n_rptr;
      if (reg_wr && reg_addr == A_CMD) r_cmd <= reg_wdata;
      if (reg_wr && reg_addr == A_ADR) r_adr <= reg_wdata;
      if (reg_wr && reg_addr == A_D1)  r_d1 <= reg_wdata;
      if (reg_wr && reg_addr == A_AUX) aux <= reg_wdata[1:0];
      if (soft_rst) begin
        stat <= '0; idx <= '0; op_done <= 1'b1; wt <= W_NONE; eng_start <= 1'b0;
      end else begin
        stat <= n_stat; idx <= n_idx; op_done <= n_op; wt <= n_wt; eng_start <= start_p;
      end
    end
  end
endmodule

// File: rtl/smbus_blk_host_chk.sv
module smbus_blk_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       eng_start,
  input logic       eng_done,
  input logic [7:0] stat,
  input logic [5:0] idx,
  input logic [1:0] aux,
  input logic [7:0] r_adr,
  input logic [7:0] r_d0,
  input logic       op_done
);
  a_r2_busy_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h00 && aux[1] && stat[0] && !eng_done && !soft_rst) |=> stat[0]);

  a_r3_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 6'h02) |-> !reg_rdata[6]);

  a_r1_aux_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 6'h0D) |-> reg_rdata[7:2] == 6'b0);

  a_r4_kill_state: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h02 && reg_wdata[1] && !soft_rst)
      |=> (stat[4] && !stat[0] && idx == 6'd0 && !eng_start));

  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat == 8'h00 && idx == 6'd0 && op_done));

  a_r7_mismatch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h02 && reg_wdata[6] && !reg_wdata[1] && reg_wdata[4:2] == 3'd5
     && aux[1] && !r_adr[0] && op_done && {2'b0, idx} != r_d0 && !soft_rst && !reg_rd)
      |=> (stat[2] && !eng_start));

  a_r13_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
endmodule

bind smbus_blk_host smbus_blk_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .eng_start(eng_start), .eng_done(eng_done), .stat(stat), .idx(idx), .aux(aux),
  .r_adr(r_adr), .r_d0(r_d0), .op_done(op_done)
);

// File: tb/smbus_blk_host_bench.sv
module smbus_blk_host_bench;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic eng_start, eng_read;
  logic [6:0] eng_addr;
  logic [7:0] eng_cmd, eng_count, eng_wbyte;
  logic [4:0] eng_widx = '0;
  logic eng_rvalid = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [7:0] eng_rbyte = '0, eng_rcount = '0;

  int total = 0, bad = 0, starts = 0, cap_n = 0, m_len = 0;
  logic m_fail = 1'b0;
  logic [7:0] m_dat [8];
  logic [7:0] cap [64];
  logic [6:0] last_addr;

  always #2 clk = ~clk;

  smbus_blk_host u_smbus_blk_host (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [5:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic settle(); repeat (40) @(negedge clk); endtask

  task automatic sreset();
    @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        starts++; last_addr = eng_addr;
        repeat (3) @(negedge clk);
        if (eng_read) begin
          for (int k = 0; k < m_len; k++) begin
            eng_rvalid = 1'b1; eng_rbyte = m_dat[k]; @(negedge clk);
          end
          eng_rvalid = 1'b0;
        end else begin
          cap_n = 0;
          for (int k = 0; k < int'(eng_count); k++) begin
            eng_widx = 5'(k); #1 cap[k] = eng_wbyte; cap_n = k + 1; @(negedge clk);
          end
        end
        eng_done = 1'b1; eng_err = m_fail; eng_rcount = 8'(m_len);
        @(negedge clk); eng_done = 1'b0; eng_err = 1'b0;
      end
    end
  end

  task automatic t_reset();
    expect_reg("R1 status", 6'h00, 8'h00);
    expect_reg("R1 control", 6'h02, 8'h00);
    expect_reg("R1 data0", 6'h05, 8'h00);
    wr(6'h0D, 8'hFF);
    expect_reg("R1 aux mask", 6'h0D, 8'h03);
    wr(6'h0D, 8'h00);
  endtask

  task automatic t_buf_write();
    int s0;
    sreset(); wr(6'h0D, 8'h02); wr(6'h04, 8'h50);
    for (int k = 0; k < 3; k++) wr(6'h07, 8'hA0 + 8'(k));
    wr(6'h05, 8'd4); s0 = starts;
    wr(6'h02, 8'h54); settle();
    expect_reg("R7 mismatch derr", 6'h00, 8'h04);
    chk("R7 no engine start", 8'(starts - s0), 8'd0);
    wr(6'h00, 8'hFF);
    expect_reg("R2 clear", 6'h00, 8'h00);
    for (int k = 0; k < 4; k++) wr(6'h07, 8'hB0 + 8'(k));
    wr(6'h02, 8'h54); settle();
    expect_reg("R7 write done", 6'h00, 8'h02);
    chk("R7 count", 8'(cap_n), 8'd4);
    chk("R7 byte0", cap[0], 8'hB0);
    chk("R7 byte3", cap[3], 8'hB3);
    chk("R13 address", {1'b0, last_addr}, 8'h28);
  endtask

  task automatic t_buf_read();
    sreset(); wr(6'h0D, 8'h02); wr(6'h04, 8'h55);
    m_len = 3; m_dat[0] = 8'h11; m_dat[1] = 8'h22; m_dat[2] = 8'h33;
    wr(6'h02, 8'h54); settle();
    expect_reg("R3 start reads 0", 6'h02, 8'h14);
    expect_reg("R6 count in data0", 6'h05, 8'h03);
    expect_reg("R6 busy+intr", 6'h00, 8'h03);
    wr(6'h00, 8'h01);
    expect_reg("R2 busy kept", 6'h00, 8'h03);
    expect_reg("R6 byte0", 6'h07, 8'h11);
    expect_reg("R6 byte1", 6'h07, 8'h22);
    expect_reg("R6 byte2", 6'h07, 8'h33);
    expect_reg("R6 busy cleared", 6'h00, 8'h02);
  endtask

  task automatic t_byte_read();
    sreset(); wr(6'h0D, 8'h00); wr(6'h04, 8'h21);
    m_len = 4; m_dat[0] = 8'h05; m_dat[1] = 8'h06; m_dat[2] = 8'h07; m_dat[3] = 8'h08;
    wr(6'h02, 8'h54); settle();
    expect_reg("R8 first status", 6'h00, 8'h81);
    expect_reg("R8 first byte", 6'h07, 8'h05);
    wr(6'h00, 8'h80);
    expect_reg("R8 second status", 6'h00, 8'h81);
    expect_reg("R8 second byte", 6'h07, 8'h06);
    wr(6'h02, 8'h34); wr(6'h00, 8'h80);
    expect_reg("R8 last status", 6'h00, 8'h02);
    expect_reg("R8 last byte", 6'h07, 8'h07);
  endtask

  task automatic t_byte_write();
    sreset(); wr(6'h0D, 8'h00); wr(6'h04, 8'h20); wr(6'h05, 8'd3);
    wr(6'h07, 8'hC1); wr(6'h02, 8'h54);
    expect_reg("R9 start status", 6'h00, 8'h81);
    wr(6'h07, 8'hC2); wr(6'h00, 8'h80);
    expect_reg("R9 step status", 6'h00, 8'h81);
    wr(6'h07, 8'hC3); wr(6'h00, 8'h80); wr(6'h00, 8'h80); settle();
    expect_reg("R9 done status", 6'h00, 8'h02);
    chk("R9 count", 8'(cap_n), 8'd3);
    chk("R9 byte0", cap[0], 8'hC1);
    chk("R9 byte1", cap[1], 8'hC2);
    chk("R9 byte2", cap[2], 8'hC3);
  endtask

  task automatic t_i2c_kill();
    int s0;
    sreset(); wr(6'h0D, 8'h00); wr(6'h04, 8'h20); wr(6'h05, 8'd1);
    wr(6'h07, 8'hD1); s0 = starts;
    wr(6'h02, 8'h58); wr(6'h00, 8'h80); settle();
    expect_reg("R10 derr", 6'h00, 8'h05);
    chk("R10 no engine start", 8'(starts - s0), 8'd0);
    wr(6'h02, 8'h02);
    expect_reg("R4 kill status", 6'h00, 8'h14);
  endtask

  task automatic t_eng_err();
    sreset(); wr(6'h0D, 8'h02); wr(6'h04, 8'h31);
    m_len = 2; m_fail = 1'b1;
    wr(6'h02, 8'h54); settle(); m_fail = 1'b0;
    expect_reg("R12 engine error", 6'h00, 8'h04);
  endtask

  task automatic t_soft_reset();
    wr(6'h0D, 8'h02); wr(6'h00, 8'h00);
    wr(6'h07, 8'hE0); wr(6'h07, 8'hE1);
    sreset();
    expect_reg("R11 status cleared", 6'h00, 8'h00);
    wr(6'h04, 8'h20); wr(6'h07, 8'hE9); wr(6'h05, 8'd1);
    wr(6'h02, 8'h54); settle();
    expect_reg("R11 index reset", 6'h00, 8'h02);
    chk("R11 byte", cap[0], 8'hE9);
  endtask

  task automatic t_wrap();
    sreset(); wr(6'h0D, 8'h02); wr(6'h04, 8'h20);
    for (int k = 0; k < 33; k++) wr(6'h07, 8'h40 + 8'(k));
    wr(6'h05, 8'd1); wr(6'h02, 8'h54); settle();
    expect_reg("R5 wrap status", 6'h00, 8'h02);
    chk("R5 wrapped byte", cap[0], 8'h60);
    wr(6'h0D, 8'h00); wr(6'h07, 8'h5A);
    expect_reg("R5 holding register", 6'h07, 8'h5A);
    expect_reg("R5 holding register again", 6'h07, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_buf_write();
    t_buf_read();
    t_byte_read();
    t_byte_write();
    t_i2c_kill();
    t_eng_err();
    t_soft_reset();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule